// File: doc/BRIEF.md
# Write Data Polarity Controller

This block sits in front of a differential head write driver and decides two things every clock: whether the driver may run, and which direction the write current flows. The write data pin arrives without a relation to the system clock, so it passes through a synchronizer. Edges are then found on the synchronized level. A mode input selects how the data is read. In level mode (NRZ), the current direction reverses each time the data level changes. In pulse mode (RZ), the direction reverses on each falling edge of the data.

Writing is requested by holding the active-low gate input LOW. When writing starts, the block captures the 7-bit current magnitude code and holds it steady for the driver's DAC until writing ends. A low-supply failure flag overrides the gate and shuts the driver off. The same write-active condition drives three side controls: it switches the AC part of the bias circuit off, it selects the low (10 mA) bias current limit, and it enables the open/short write-coil detector.

The control is a three-state machine with these transitions:
- IDLE to WRITE: gate LOW and no power failure.
- WRITE to IDLE: gate HIGH.
- IDLE or WRITE to PWRFAIL: power-fail flag HIGH. This transition has priority over the others.
- PWRFAIL to IDLE: flag LOW.

The gate, mode, code and power-fail inputs are taken as synchronous to the clock.

Top module: `wrpol_ctrl`

## Requirements
- R1: After reset, the outputs are: driver enable 0, polarity 1 (positive), latched code 0, and all three side controls 0.
- R2: If the gate is sampled LOW with no power failure while in IDLE, the driver enable goes to 1 after that clock edge. If the gate is sampled HIGH, the driver enable is 0 after that edge.
- R3: In NRZ mode (mode input 0), entering WRITE loads the polarity from the synchronized data level. While writing continues, the polarity inverts on each clock in which the synchronized data level differs from its value one clock earlier.
- R4: In RZ mode (mode input 1), entering WRITE sets the polarity to 1. While writing continues, the polarity inverts only on a falling edge of the synchronized data (previous 1, current 0).
- R5: A change at the data pin first affects the polarity output after the third rising clock edge (two synchronizer flops, then the polarity register).
- R6: The current code is captured on the edge that enters WRITE. It stays unchanged while WRITE lasts, whatever the code input does.
- R7: The AC bias off, low bias limit select and coil detector enable outputs are each 1 exactly while the driver enable is 1.
- R8: A power-fail flag sampled HIGH makes the driver enable 0 after that edge. The enable stays 0 while the flag is HIGH. Once the flag is sampled LOW, the machine passes through one IDLE cycle before it can write again.
- R9: Outside WRITE, data activity leaves the polarity output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wd_in | input | 1 | write data pin, asynchronous |
| wgate_n | input | 1 | write gate, active LOW |
| rz_mode | input | 1 | 1 = RZ (falling-edge toggle), 0 = NRZ (level follow) |
| cur_code_i | input | 7 | requested write current code |
| pf5_i | input | 1 | 5 V supply failure flag, active HIGH |
| pol_o | output | 1 | write current polarity, 1 = positive |
| drv_en_o | output | 1 | write driver enable |
| cur_code_o | output | 7 | code held for the current DAC |
| ac_bias_off_o | output | 1 | switches the AC bias circuit off |
| bias_lim_lo_o | output | 1 | selects the 10 mA bias current limit |
| unsafe_en_o | output | 1 | enables the write-unsafe detector |

## Verification
The data pin is driven in both modes with several patterns: random toggles at high density, long steady stretches, and single isolated edges. These patterns separate level following from falling-edge toggling. They also show whether a rising edge wrongly flips the polarity in RZ mode. Gate drops that land on different data levels check the entry rules (load from data versus forced positive). Power-fail pulses that arrive during writing and during idle check the override priority and the IDLE pass after the flag clears. A directed step on a single data edge pins down the three-edge latency, and data toggling while idle shows that the polarity holds.

// File: rtl/wrpol_pkg.sv
package wrpol_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WRITE   = 2'd1,
        ST_PWRFAIL = 2'd2
    } wr_state_t;
endpackage

// File: rtl/wrpol_sync.sv
module wrpol_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wrpol_polarity.sv
module wrpol_polarity #(
    parameter logic POL_RESET = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_s_i,
    input  logic rz_i,
    input  logic load_i,
    input  logic run_i,
    output logic pol_o
);
    logic wd_d_q;
    logic pol_q;
    logic fall_w;
    logic chg_w;
    logic flip_w;

    assign fall_w = wd_d_q & ~wd_s_i;
    assign chg_w  = wd_d_q ^ wd_s_i;
    assign flip_w = rz_i ? fall_w : chg_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_d_q <= 1'b0;
            pol_q  <= POL_RESET;
        end else begin
            wd_d_q <= wd_s_i;
            if (load_i)     pol_q <= rz_i ? POL_RESET : wd_s_i;
            else if (run_i) pol_q <= pol_q ^ flip_w;
        end
    end

    assign pol_o = pol_q;

    // R4
    rz_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && rz_i) |=> pol_o);
    // R3
    nrz_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((load_i || run_i) && !rz_i) |=> (pol_o == $past(wd_s_i)));
    // R4
    rz_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && rz_i && !wd_d_q && wd_s_i) |=> $stable(pol_o));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !run_i) |=> $stable(pol_o));
endmodule

// File: rtl/wrpol_ctrl.sv
module wrpol_ctrl #(
    parameter int CODE_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wd_in,
    input  logic              wgate_n,
    input  logic              rz_mode,
    input  logic [CODE_W-1:0] cur_code_i,
    input  logic              pf5_i,
    output logic              pol_o,
    output logic              drv_en_o,
    output logic [CODE_W-1:0] cur_code_o,
    output logic              ac_bias_off_o,
    output logic              bias_lim_lo_o,
    output logic              unsafe_en_o
);
    import wrpol_pkg::*;

    wr_state_t         state_q, state_d;
    logic              wd_s;
    logic              enter_w;
    logic              run_w;
    logic              writing;
    logic [CODE_W-1:0] code_q;

    wrpol_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (wd_in),
        .q_o   (wd_s)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pf5_i)         state_d = ST_PWRFAIL;
                else if (!wgate_n) state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (pf5_i)         state_d = ST_PWRFAIL;
                else if (wgate_n)  state_d = ST_IDLE;
            end
            ST_PWRFAIL: begin
                if (!pf5_i)        state_d = ST_IDLE;
            end
            default:               state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        writing = 1'b0;
        unique case (state_q)
            ST_WRITE: writing = 1'b1;
            default:  writing = 1'b0;
        endcase
    end

    assign enter_w = (state_q != ST_WRITE) && (state_d == ST_WRITE);
    assign run_w   = (state_q == ST_WRITE) && (state_d == ST_WRITE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       code_q <= '0;
        else if (enter_w) code_q <= cur_code_i;
    end

    wrpol_polarity #(.POL_RESET(1'b1)) u_pol (
        .clk    (clk),
        .rst_n  (rst_n),
        .wd_s_i (wd_s),
        .rz_i   (rz_mode),
        .load_i (enter_w),
        .run_i  (run_w),
        .pol_o  (pol_o)
    );

    assign drv_en_o      = writing;
    assign ac_bias_off_o = writing;
    assign bias_lim_lo_o = writing;
    assign unsafe_en_o   = writing;
    assign cur_code_o    = code_q;

    // R8
    pf_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf5_i |=> !drv_en_o);
    // R2
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wgate_n |=> !drv_en_o);
    // R2
    gate_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !wgate_n && !pf5_i) |=> drv_en_o);
    // R6
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en_o && $past(drv_en_o)) |-> $stable(cur_code_o));
    // R8
    pf_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PWRFAIL) |=> (state_q != ST_WRITE));
endmodule

// File: tb/wrpol_ctrl_tb.sv
module wrpol_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wd_in = 1'b0;
    logic       wgate_n = 1'b1;
    logic       rz_mode = 1'b0;
    logic [6:0] cur_code_i = 7'd0;
    logic       pf5_i = 1'b0;
    logic       pol_o, drv_en_o, ac_bias_off_o, bias_lim_lo_o, unsafe_en_o;
    logic [6:0] cur_code_o;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    wrpol_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wd_in(wd_in), .wgate_n(wgate_n),
        .rz_mode(rz_mode), .cur_code_i(cur_code_i), .pf5_i(pf5_i),
        .pol_o(pol_o), .drv_en_o(drv_en_o), .cur_code_o(cur_code_o),
        .ac_bias_off_o(ac_bias_off_o), .bias_lim_lo_o(bias_lim_lo_o),
        .unsafe_en_o(unsafe_en_o)
    );

    // reference model built from the requirements (0 idle, 1 write, 2 power fail)
    logic       m_s1, m_s2, m_d, m_pol;
    logic [1:0] m_st;
    logic [6:0] m_code;

    function automatic logic flip_of(input logic rz, input logic prev, input logic cur);
        return rz ? (prev & ~cur) : (prev ^ cur);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_d <= 0; m_pol <= 1; m_st <= 0; m_code <= 0;
        end else begin
            m_s1 <= wd_in; m_s2 <= m_s1; m_d <= m_s2;
            case (m_st)
                2'd0: if (pf5_i) m_st <= 2;
                      else if (!wgate_n) begin
                          m_st <= 1; m_code <= cur_code_i;
                          m_pol <= rz_mode ? 1'b1 : m_s2;
                      end
                2'd1: if (pf5_i) m_st <= 2;
                      else if (wgate_n) m_st <= 0;
                      else m_pol <= m_pol ^ flip_of(rz_mode, m_d, m_s2);
                default: if (!pf5_i) m_st <= 0;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        logic w;
        w = (m_st == 2'd1);
        chk(rz_mode ? "R4 polarity" : "R3 polarity", {6'd0, pol_o}, {6'd0, m_pol});
        chk("R2 driver enable", {6'd0, drv_en_o}, {6'd0, w});
        chk("R6 latched code", cur_code_o, m_code);
        chk("R7 side controls", {4'd0, ac_bias_off_o, bias_lim_lo_o, unsafe_en_o}, {4'd0, w, w, w});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmp_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic p0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 drv_en", {6'd0, drv_en_o}, 7'd0);
        chk("R1 pol", {6'd0, pol_o}, 7'd1);
        chk("R1 code", cur_code_o, 7'd0);
        chk("R1 side", {4'd0, ac_bias_off_o, bias_lim_lo_o, unsafe_en_o}, 7'd0);
        rst_n = 1'b1;
        tick();

        // R5 latency: NRZ write with data steady low, then one edge
        rz_mode = 0; wd_in = 0; cur_code_i = 7'h55; wgate_n = 0;
        repeat (4) tick();
        chk("R3 entry load", {6'd0, pol_o}, 7'd0);
        cur_code_i = 7'h12;
        wd_in = 1;
        tick(); chk("R5 edge1", {6'd0, pol_o}, 7'd0);
        tick(); chk("R5 edge2", {6'd0, pol_o}, 7'd0);
        tick(); chk("R5 edge3", {6'd0, pol_o}, 7'd1);
        chk("R6 held", cur_code_o, 7'h55);

        // R8 power fail during write
        pf5_i = 1;
        tick(); chk("R8 off", {6'd0, drv_en_o}, 7'd0);
        tick(); chk("R8 stays off", {6'd0, drv_en_o}, 7'd0);
        pf5_i = 0;
        tick(); chk("R8 idle pass", {6'd0, drv_en_o}, 7'd0);
        tick(); chk("R8 re-entry", {6'd0, drv_en_o}, 7'd1);

        // R9 idle activity
        wgate_n = 1;
        tick();
        p0 = pol_o;
        for (int i = 0; i < 12; i++) begin
            wd_in = ~wd_in;
            tick();
            chk("R9 idle hold", {6'd0, pol_o}, {6'd0, p0});
        end

        // R4 RZ entry on low data, rising edge no flip, falling edge flips
        rz_mode = 1; wd_in = 0;
        repeat (3) tick();
        wgate_n = 0;
        tick(); chk("R4 entry positive", {6'd0, pol_o}, 7'd1);
        wd_in = 1; repeat (3) tick();
        chk("R4 rise ignored", {6'd0, pol_o}, 7'd1);
        wd_in = 0; repeat (3) tick();
        chk("R4 fall flips", {6'd0, pol_o}, 7'd0);
        wgate_n = 1; tick();

        // constrained random
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(0, 39) == 0) wgate_n = ~wgate_n;
            if (wgate_n && $urandom_range(0, 9) == 0) rz_mode = $urandom_range(0, 1) == 1;
            if ($urandom_range(0, 2) == 0) wd_in = ~wd_in;
            if ($urandom_range(0, 3) == 0) cur_code_i = 7'($urandom_range(0, 127));
            pf5_i = pf5_i ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 299) == 0);
            tick();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule